// File: doc/BRIEF.md
# PHY Control-Register Indirect Access Engine

This block is a small hardware master that carries out one read or one write at a time into the private register space of a PHY. That space is not mapped directly. It is reached through a window of six bus registers. A value is staged in an input holding register. Self-clearing strobe registers then latch that value as an address or as data, and command strobes start the transfer. The engine turns one front-side request into the full chain of window accesses. It polls each strobe until it clears, paces the polls, and gives up after a bounded number of attempts.

A client raises `req_valid` with a direction flag, a 16-bit PHY address and, for writes, 16-bit data. The engine accepts the request only while it is idle. When the access ends, `rsp_done` is high for one cycle. `rsp_err` is high in the same cycle if some strobe never cleared. For a read, `rsp_rdata` holds the result from that cycle on. The first read result after an address capture can be corrupt, so every read runs its command-and-sample step twice and keeps only the second sample.

On the back side the engine issues one bus access at a time. Each access uses a write strobe or a read strobe, an 8-bit byte offset and a 32-bit data word. The access completes in the cycle the target raises `bus_ack`.

Top module: `phyreg_bridge`

## Requirements
- R1: After reset `req_ready` is 1, `rsp_done` and `rsp_err` are 0, and neither `bus_wr` nor `bus_rd` is asserted.
- R2: A request is taken in a cycle with `req_valid` and `req_ready` both high. `req_ready` stays low from the next cycle until the access ends. `rsp_done` is a single-cycle pulse, and `rsp_err` is only ever high together with `rsp_done`.
- R3: At most one of `bus_wr` and `bus_rd` is high. Once raised, a strobe and its `bus_addr` and `bus_wdata` hold steady until the cycle in which `bus_ack` is high.
- R4: A write issues, in order: write the PHY address to offset 0x0C, write 1 to 0x14, poll 0x14; write the data to 0x0C, write 1 to 0x18, poll 0x18; write 1 to 0x20, poll 0x20. It then ends with `rsp_err` low.
- R5: A read issues: write the PHY address to 0x0C, write 1 to 0x14, poll 0x14. It then does the following pair twice: write 1 to 0x1C, poll 0x1C, read 0x10. `rsp_rdata` is bits 15:0 of the second read of 0x10.
- R6: Polling reads the strobe register until the returned 32-bit word is zero. A strobe that reads zero on attempt POLL_LIMIT (10 by default) still counts as cleared.
- R7: If POLL_LIMIT polls of one strobe all return nonzero, the access ends at once with `rsp_done` and `rsp_err` high. No further bus access is issued for that request, and `rsp_rdata` is not updated.
- R8: After a poll that returns nonzero, at least POLL_GAP clock cycles pass before the next poll of that strobe is acknowledged.
- R9: Staged addresses and data are written zero-extended to 32 bits, and every strobe or command write carries the value 1. Reads drive `bus_wdata` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle; a request is accepted this cycle |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | 16 | PHY register address |
| req_wdata | input | 16 | Write data |
| rsp_done | output | 1 | One-cycle end-of-access pulse |
| rsp_err | output | 1 | Timeout flag, valid with rsp_done |
| rsp_rdata | output | 16 | Read result, updated on a successful read |
| bus_wr | output | 1 | Window bus write strobe |
| bus_rd | output | 1 | Window bus read strobe |
| bus_addr | output | 8 | Window register byte offset |
| bus_wdata | output | 32 | Window bus write data |
| bus_rdata | input | 32 | Window bus read data |
| bus_ack | input | 1 | Window bus access complete |

## Verification
A corrupt step pointer or direction flag shows up first on the bus. The next window access after the corruption has the wrong offset or data. The bench compares every bus access of each request against a sequence computed from the strobe busy counts it programs, so the error is caught at the `rsp_done` of that same request. A wrong retry count shows as too few or too many polls, or as a missing or spurious `rsp_err`. A dropped second read pass returns the corrupted first sample in `rsp_rdata`. A broken pacing counter shrinks the measured spacing between acknowledged polls.

// File: rtl/phyreg_pkg.sv
package phyreg_pkg;

    localparam int BUS_AW = 8;
    localparam int BUS_DW = 32;

    localparam logic [BUS_AW-1:0] OFS_STAGE   = 8'h0C;
    localparam logic [BUS_AW-1:0] OFS_RESULT  = 8'h10;
    localparam logic [BUS_AW-1:0] OFS_LATCH_A = 8'h14;
    localparam logic [BUS_AW-1:0] OFS_LATCH_D = 8'h18;
    localparam logic [BUS_AW-1:0] OFS_GO_RD   = 8'h1C;
    localparam logic [BUS_AW-1:0] OFS_GO_WR   = 8'h20;

    typedef enum logic [3:0] {
        ST_A_LOAD,
        ST_A_STROBE,
        ST_A_POLL,
        ST_D_LOAD,
        ST_D_STROBE,
        ST_D_POLL,
        ST_W_STROBE,
        ST_W_POLL,
        ST_R_STROBE,
        ST_R_POLL,
        ST_R_SAMPLE
    } step_e;

    typedef enum logic [1:0] {
        C_IDLE,
        C_ISSUE,
        C_WAIT,
        C_GAP
    } ctl_e;

    typedef struct packed {
        logic              wr;
        logic [BUS_AW-1:0] addr;
        logic [BUS_DW-1:0] data;
    } bus_op_t;

    function automatic logic is_poll(step_e s);
        return (s == ST_A_POLL) || (s == ST_D_POLL) ||
               (s == ST_W_POLL) || (s == ST_R_POLL);
    endfunction

    function automatic bus_op_t step_op(step_e s,
                                        logic [BUS_DW-1:0] a,
                                        logic [BUS_DW-1:0] d);
        bus_op_t o;
        o.wr   = 1'b1;
        o.addr = OFS_STAGE;
        o.data = '0;
        case (s)
            ST_A_LOAD:   o.data = a;
            ST_D_LOAD:   o.data = d;
            ST_A_STROBE: begin o.addr = OFS_LATCH_A; o.data = 32'd1; end
            ST_D_STROBE: begin o.addr = OFS_LATCH_D; o.data = 32'd1; end
            ST_W_STROBE: begin o.addr = OFS_GO_WR;   o.data = 32'd1; end
            ST_R_STROBE: begin o.addr = OFS_GO_RD;   o.data = 32'd1; end
            ST_A_POLL:   begin o.wr = 1'b0; o.addr = OFS_LATCH_A; end
            ST_D_POLL:   begin o.wr = 1'b0; o.addr = OFS_LATCH_D; end
            ST_W_POLL:   begin o.wr = 1'b0; o.addr = OFS_GO_WR;   end
            ST_R_POLL:   begin o.wr = 1'b0; o.addr = OFS_GO_RD;   end
            ST_R_SAMPLE: begin o.wr = 1'b0; o.addr = OFS_RESULT;  end
            default: ;
        endcase
        return o;
    endfunction

    function automatic step_e step_after(step_e s, logic write);
        step_e n;
        case (s)
            ST_A_LOAD:   n = ST_A_STROBE;
            ST_A_STROBE: n = ST_A_POLL;
            ST_A_POLL:   n = write ? ST_D_LOAD : ST_R_STROBE;
            ST_D_LOAD:   n = ST_D_STROBE;
            ST_D_STROBE: n = ST_D_POLL;
            ST_D_POLL:   n = ST_W_STROBE;
            ST_W_STROBE: n = ST_W_POLL;
            ST_R_STROBE: n = ST_R_POLL;
            ST_R_POLL:   n = ST_R_SAMPLE;
            default:     n = ST_R_STROBE;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/phyreg_bus_port.sv
module phyreg_bus_port
    import phyreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              op_go,
    input  bus_op_t           op_in,
    output logic              op_fin,
    output logic [BUS_DW-1:0] op_rdata,
    output logic              bus_wr,
    output logic              bus_rd,
    output logic [BUS_AW-1:0] bus_addr,
    output logic [BUS_DW-1:0] bus_wdata,
    input  logic [BUS_DW-1:0] bus_rdata,
    input  logic              bus_ack
);

    logic              wr_q, rd_q, fin_q;
    logic [BUS_AW-1:0] addr_q;
    logic [BUS_DW-1:0] wdata_q, rdata_q;
    logic              active;

    assign active = wr_q | rd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q    <= 1'b0;
            rd_q    <= 1'b0;
            fin_q   <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            fin_q <= 1'b0;
            if (active && bus_ack) begin
                wr_q    <= 1'b0;
                rd_q    <= 1'b0;
                fin_q   <= 1'b1;
                rdata_q <= bus_rdata;
            end else if (op_go && !active) begin
                wr_q    <= op_in.wr;
                rd_q    <= ~op_in.wr;
                addr_q  <= op_in.addr;
                wdata_q <= op_in.wr ? op_in.data : '0;
            end
        end
    end

    assign op_fin    = fin_q;
    assign op_rdata  = rdata_q;
    assign bus_wr    = wr_q;
    assign bus_rd    = rd_q;
    assign bus_addr  = addr_q;
    assign bus_wdata = wdata_q;

endmodule

// File: rtl/phyreg_poll_pacer.sv
module phyreg_poll_pacer #(
    parameter int POLL_LIMIT = 10,
    parameter int POLL_GAP   = 2000
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic miss,
    output logic last_try,
    output logic gap_idle
);

    localparam int RW = $clog2(POLL_LIMIT + 1);
    localparam logic [RW-1:0] LAST = RW'(POLL_LIMIT - 1);

    logic [RW-1:0] tries_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            tries_q <= '0;
        end else if (miss && tries_q != LAST) begin
            tries_q <= tries_q + 1'b1;
        end
    end

    assign last_try = (tries_q == LAST);

    generate
        if (POLL_GAP == 0) begin : g_nogap
            assign gap_idle = 1'b1;
        end else begin : g_gap
            localparam int GW = $clog2(POLL_GAP + 1);
            logic [GW-1:0] gap_q;
            always_ff @(posedge clk) begin
                if (rst || clr) begin
                    gap_q <= '0;
                end else if (miss) begin
                    gap_q <= GW'(POLL_GAP);
                end else if (gap_q != '0) begin
                    gap_q <= gap_q - 1'b1;
                end
            end
            assign gap_idle = (gap_q == '0);
        end
    endgenerate

endmodule

// File: rtl/phyreg_sequencer.sv
module phyreg_sequencer
    import phyreg_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_done,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              op_go,
    output bus_op_t           op_out,
    input  logic              op_fin,
    input  logic [BUS_DW-1:0] op_rdata,
    output logic              pace_clr,
    output logic              pace_miss,
    input  logic              pace_last,
    input  logic              pace_idle
);

    ctl_e              ctl_q;
    step_e             step_q;
    logic              write_q, second_q;
    logic [BUS_DW-1:0] addr_q, wdata_q;
    logic [DATA_W-1:0] rdata_q;
    logic              done_q, err_q;
    logic              poll_back, cleared;

    assign req_ready = (ctl_q == C_IDLE);
    assign op_go     = (ctl_q == C_ISSUE);
    assign op_out    = step_op(step_q, addr_q, wdata_q);

    assign poll_back = (ctl_q == C_WAIT) && op_fin && is_poll(step_q);
    assign cleared   = (op_rdata == '0);
    assign pace_clr  = (poll_back && cleared) || (req_ready && req_valid);
    assign pace_miss = poll_back && !cleared;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q    <= C_IDLE;
            step_q   <= ST_A_LOAD;
            write_q  <= 1'b0;
            second_q <= 1'b0;
            addr_q   <= '0;
            wdata_q  <= '0;
            rdata_q  <= '0;
            done_q   <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            case (ctl_q)
                C_IDLE: begin
                    if (req_valid) begin
                        write_q  <= req_write;
                        addr_q   <= BUS_DW'(req_addr);
                        wdata_q  <= BUS_DW'(req_wdata);
                        second_q <= 1'b0;
                        step_q   <= ST_A_LOAD;
                        ctl_q    <= C_ISSUE;
                    end
                end
                C_ISSUE: ctl_q <= C_WAIT;
                C_WAIT: begin
                    if (op_fin) begin
                        if (is_poll(step_q)) begin
                            if (cleared) begin
                                if (step_q == ST_W_POLL) begin
                                    done_q <= 1'b1;
                                    ctl_q  <= C_IDLE;
                                end else begin
                                    step_q <= step_after(step_q, write_q);
                                    ctl_q  <= C_ISSUE;
                                end
                            end else if (pace_last) begin
                                done_q <= 1'b1;
                                err_q  <= 1'b1;
                                ctl_q  <= C_IDLE;
                            end else begin
                                ctl_q <= C_GAP;
                            end
                        end else if (step_q == ST_R_SAMPLE) begin
                            if (second_q) begin
                                rdata_q <= op_rdata[DATA_W-1:0];
                                done_q  <= 1'b1;
                                ctl_q   <= C_IDLE;
                            end else begin
                                second_q <= 1'b1;
                                step_q   <= ST_R_STROBE;
                                ctl_q    <= C_ISSUE;
                            end
                        end else begin
                            step_q <= step_after(step_q, write_q);
                            ctl_q  <= C_ISSUE;
                        end
                    end
                end
                C_GAP: begin
                    if (pace_idle) ctl_q <= C_ISSUE;
                end
                default: ctl_q <= C_IDLE;
            endcase
        end
    end

    assign rsp_done  = done_q;
    assign rsp_err   = err_q;
    assign rsp_rdata = rdata_q;

endmodule

// File: rtl/phyreg_bridge.sv
module phyreg_bridge
    import phyreg_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 16,
    parameter int POLL_LIMIT = 10,
    parameter int POLL_GAP   = 2000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_done,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              bus_wr,
    output logic              bus_rd,
    output logic [7:0]        bus_addr,
    output logic [31:0]       bus_wdata,
    input  logic [31:0]       bus_rdata,
    input  logic              bus_ack
);

    bus_op_t           op;
    logic              op_go, op_fin;
    logic [BUS_DW-1:0] op_rdata;
    logic              pace_clr, pace_miss, pace_last, pace_idle;

    phyreg_sequencer #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .rsp_done  (rsp_done),
        .rsp_err   (rsp_err),
        .rsp_rdata (rsp_rdata),
        .op_go     (op_go),
        .op_out    (op),
        .op_fin    (op_fin),
        .op_rdata  (op_rdata),
        .pace_clr  (pace_clr),
        .pace_miss (pace_miss),
        .pace_last (pace_last),
        .pace_idle (pace_idle)
    );

    phyreg_poll_pacer #(
        .POLL_LIMIT(POLL_LIMIT),
        .POLL_GAP  (POLL_GAP)
    ) u_pace (
        .clk      (clk),
        .rst      (rst),
        .clr      (pace_clr),
        .miss     (pace_miss),
        .last_try (pace_last),
        .gap_idle (pace_idle)
    );

    phyreg_bus_port u_port (
        .clk       (clk),
        .rst       (rst),
        .op_go     (op_go),
        .op_in     (op),
        .op_fin    (op_fin),
        .op_rdata  (op_rdata),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .bus_ack   (bus_ack)
    );

endmodule

// File: rtl/phyreg_bridge_chk.sv
module phyreg_bridge_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        req_ready,
    input logic        rsp_done,
    input logic        rsp_err,
    input logic        bus_wr,
    input logic        bus_rd,
    input logic [7:0]  bus_addr,
    input logic [31:0] bus_wdata,
    input logic        bus_ack
);

    // R3
    a_r3_single_strobe: assert property (@(posedge clk) disable iff (rst)
        !(bus_wr && bus_rd));

    // R3
    a_r3_hold_until_ack: assert property (@(posedge clk) disable iff (rst)
        ((bus_wr || bus_rd) && !bus_ack) |=>
        (bus_wr == $past(bus_wr) && bus_rd == $past(bus_rd) &&
         $stable(bus_addr) && $stable(bus_wdata)));

    // R2
    a_r2_done_pulse: assert property (@(posedge clk) disable iff (rst)
        rsp_done |=> !rsp_done);

    // R2
    a_r2_busy_after_take: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    // R7
    a_r7_err_with_done: assert property (@(posedge clk) disable iff (rst)
        rsp_err |-> rsp_done);

    // R1
    a_r1_idle_bus_quiet: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !(bus_wr || bus_rd));

    // R9
    a_r9_strobe_value: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && (bus_addr == 8'h14 || bus_addr == 8'h18 ||
                    bus_addr == 8'h1C || bus_addr == 8'h20))
        |-> (bus_wdata == 32'd1));

    // R9
    a_r9_read_wdata_zero: assert property (@(posedge clk) disable iff (rst)
        bus_rd |-> (bus_wdata == 32'd0));

endmodule

bind phyreg_bridge phyreg_bridge_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_done  (rsp_done),
    .rsp_err   (rsp_err),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_ack   (bus_ack)
);

// File: tb/phyreg_bridge_tb.sv
`timescale 1ns/1ps
module phyreg_bridge_tb;

    localparam int LIM = 10;
    localparam int GAP = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [15:0] req_addr = '0, req_wdata = '0;
    logic        req_ready, rsp_done, rsp_err;
    logic [15:0] rsp_rdata;
    logic        bus_wr, bus_rd, bus_ack;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata, bus_rdata;

    always #2.5 clk = ~clk;

    phyreg_bridge #(.POLL_LIMIT(LIM), .POLL_GAP(GAP)) u_dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack)
    );

    int  n_run = 0, n_fail = 0;
    bit  finished = 0;
    longint cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // window model state
    logic [15:0] phy_mem [0:255];
    logic [31:0] stage_r;
    logic [15:0] lat_a, lat_d, result_r;
    bit          fresh;
    int          busy_cfg [4];
    int          busy_left [4];
    int          lat = 0, wait_cnt = 0;
    longint      last_poll = 0;
    int          miss_idx = -1;
    longint      min_gap = 1000000;

    logic [24:0] got_log [$];
    logic [24:0] exp_log [$];

    typedef struct {
        bit          wr;
        logic [15:0] d;
        bit          err;
        string       tag;
    } exp_t;
    exp_t sb [$];
    event acc_done;

    task automatic chk(bit ok, string tag, string what, longint act, longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic int sidx(logic [7:0] a);
        case (a)
            8'h14: return 0;
            8'h18: return 1;
            8'h20: return 2;
            8'h1C: return 3;
            default: return -1;
        endcase
    endfunction

    task automatic serve();
        int k;
        got_log.push_back({bus_wr, bus_addr, bus_wr ? bus_wdata[15:0] : 16'h0});
        k = sidx(bus_addr);
        bus_rdata = 32'h0;
        if (bus_wr) begin
            miss_idx = -1;
            case (bus_addr)
                8'h0C: stage_r = bus_wdata;
                8'h14: begin lat_a = stage_r[15:0]; fresh = 1; end
                8'h18: lat_d = stage_r[15:0];
                8'h20: phy_mem[lat_a[7:0]] = lat_d;
                8'h1C: begin
                    if (fresh) begin
                        result_r = ~phy_mem[lat_a[7:0]] ^ 16'h5A5A;
                        fresh = 0;
                    end else begin
                        result_r = phy_mem[lat_a[7:0]];
                    end
                end
                default: ;
            endcase
            if (k >= 0) busy_left[k] = busy_cfg[k];
        end else begin
            if (k >= 0) begin
                if (miss_idx == k && (cyc - last_poll) < min_gap)
                    min_gap = cyc - last_poll;
                last_poll = cyc;
                if (busy_left[k] > 0) begin
                    bus_rdata = 32'd1;
                    busy_left[k]--;
                    miss_idx = k;
                end else begin
                    miss_idx = -1;
                end
            end else begin
                bus_rdata = {16'h0, result_r};
                miss_idx = -1;
            end
        end
    endtask

    // bus responder
    initial begin
        bus_ack = 0;
        bus_rdata = 0;
        for (int i = 0; i < 256; i++) phy_mem[i] = 16'h0;
        stage_r = 0; lat_a = 0; lat_d = 0; result_r = 0; fresh = 0;
        for (int i = 0; i < 4; i++) begin busy_cfg[i] = 0; busy_left[i] = 0; end
        forever begin
            @(negedge clk);
            if (bus_ack) begin
                bus_ack = 0;
            end else if (bus_wr || bus_rd) begin
                if (wait_cnt < lat) begin
                    wait_cnt++;
                end else begin
                    wait_cnt = 0;
                    serve();
                    bus_ack = 1;
                end
            end
        end
    end

    // monitor / scoreboard
    initial begin
        bit prev_done = 0;
        forever begin
            @(negedge clk);
            if (rsp_done) begin
                exp_t e;
                bit same;
                e = sb.pop_front();
                chk(rsp_err == e.err, e.err ? "R7" : e.tag, "error flag", rsp_err, e.err);
                if (!e.wr && !e.err)
                    chk(rsp_rdata == e.d, "R5", "read data (second sample)", rsp_rdata, e.d);
                same = (got_log.size() == exp_log.size());
                if (same)
                    foreach (exp_log[i]) if (got_log[i] !== exp_log[i]) same = 0;
                chk(same, e.tag, "bus access sequence length", got_log.size(), exp_log.size());
                if (!same)
                    foreach (got_log[i]) $display("  bus %0d got=%h", i, got_log[i]);
                chk(!prev_done, "R2", "done width one cycle", prev_done, 0);
                -> acc_done;
            end else if (rsp_err) begin
                chk(0, "R7", "err without done", 1, 0);
            end
            prev_done = rsp_done;
        end
    end

    function automatic bit push_poll(logic [7:0] ofs, int busy);
        int n = (busy >= LIM) ? LIM : busy + 1;
        for (int i = 0; i < n; i++) exp_log.push_back({1'b0, ofs, 16'h0});
        return busy >= LIM;
    endfunction

    task automatic access(bit wr, logic [15:0] a, logic [15:0] d,
                          logic [15:0] exp_rd, string tag);
        bit ab = 0;
        exp_t e;
        got_log.delete();
        exp_log.delete();
        exp_log.push_back({1'b1, 8'h0C, a});
        exp_log.push_back({1'b1, 8'h14, 16'h1});
        ab = push_poll(8'h14, busy_cfg[0]);
        if (!ab) begin
            if (wr) begin
                exp_log.push_back({1'b1, 8'h0C, d});
                exp_log.push_back({1'b1, 8'h18, 16'h1});
                ab = push_poll(8'h18, busy_cfg[1]);
                if (!ab) begin
                    exp_log.push_back({1'b1, 8'h20, 16'h1});
                    ab = push_poll(8'h20, busy_cfg[2]);
                end
            end else begin
                for (int p = 0; p < 2; p++) begin
                    if (!ab) begin
                        exp_log.push_back({1'b1, 8'h1C, 16'h1});
                        ab = push_poll(8'h1C, busy_cfg[3]);
                        if (!ab) exp_log.push_back({1'b0, 8'h10, 16'h0});
                    end
                end
            end
        end
        e.wr = wr; e.d = exp_rd; e.err = ab; e.tag = tag;
        sb.push_back(e);
        @(negedge clk);
        req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        chk(req_ready == 0, "R2", "ready low after accept", req_ready, 0);
        req_valid = 0;
        @(acc_done);
    endtask

    task automatic set_busy(int a, int b, int c, int r);
        busy_cfg[0] = a; busy_cfg[1] = b; busy_cfg[2] = c; busy_cfg[3] = r;
    endtask

    task automatic finish_up();
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 150000);
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        finish_up();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(req_ready == 1, "R1", "ready after reset", req_ready, 1);
        chk(rsp_done == 0 && rsp_err == 0, "R1", "done/err after reset", {rsp_done, rsp_err}, 0);
        chk(!bus_wr && !bus_rd, "R1", "bus quiet after reset", {bus_wr, bus_rd}, 0);

        // basic write and read, no busy strobes (R4, R5, R9)
        set_busy(0, 0, 0, 0); lat = 0;
        access(1, 16'h0012, 16'hA5C3, 16'h0, "R4");
        access(0, 16'h0012, 16'h0, 16'hA5C3, "R5");

        // busy strobes with bus latency; pacing measured (R8)
        min_gap = 1000000;
        set_busy(2, 1, 3, 2); lat = 1;
        access(1, 16'h0134, 16'h1E0F, 16'h0, "R4");
        access(0, 16'h0134, 16'h0, 16'h1E0F, "R5");
        chk(min_gap >= GAP, "R8", "poll spacing cycles", min_gap, GAP);

        // clears on the last permitted poll (R6)
        set_busy(9, 0, 9, 9); lat = 2;
        access(1, 16'h0056, 16'hFFFF, 16'h0, "R6");
        access(0, 16'h0056, 16'h0, 16'hFFFF, "R6");

        // timeout at address capture: no later phase (R7)
        set_busy(10, 0, 0, 0); lat = 0;
        access(1, 16'h0078, 16'h1111, 16'h0, "R7");
        set_busy(0, 0, 0, 0);
        access(0, 16'h0078, 16'h0, 16'h0000, "R7");

        // timeout at data capture and at write command (R7)
        set_busy(0, 10, 0, 0);
        access(1, 16'h009A, 16'h2222, 16'h0, "R7");
        set_busy(0, 0, 10, 0);
        access(1, 16'h00BC, 16'h3333, 16'h0, "R7");

        // timeout in first read pass; rdata keeps previous value (R7)
        set_busy(0, 0, 0, 10);
        access(0, 16'h0012, 16'h0, 16'h0, "R7");
        @(negedge clk);
        chk(rsp_rdata == 16'h0000, "R7", "rdata held after timeout", rsp_rdata, 16'h0000);

        // back-to-back reads, different contents (R5)
        set_busy(0, 0, 0, 1); lat = 1;
        access(0, 16'h0134, 16'h0, 16'h1E0F, "R5");
        access(0, 16'h00FF, 16'h0, 16'h0000, "R5");
        access(1, 16'h00FF, 16'h8001, 16'h0, "R4");
        access(0, 16'h00FF, 16'h0, 16'h8001, "R5");

        repeat (4) @(negedge clk);
        finish_up();
    end

endmodule